// File: doc/BRIEF.md
# Coprocessor Operation Timeout Supervisor

This block watches over one multi-cycle operation of a custom coprocessor at a time. The processor sends a one-cycle start strobe. The supervisor then raises a busy flag and counts the cycles that follow. The coprocessor reports completion with a one-cycle valid pulse and a 32-bit result. The supervisor latches that result and gives a one-cycle done pulse.

If the valid pulse has not come within a programmable number of cycles after the start, the supervisor ends the operation on its own. It drops the busy flag and gives a one-cycle illegal-instruction pulse, which the processor turns into an exception. Valid pulses that come while no operation is running are discarded. This covers late completions that arrive after an abort. Start strobes that come while an operation is running are also discarded. The operands of the coprocessor are assumed to stay stable from start to completion, so the supervisor does not register them.

Top module: `cop_timeout_mon`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the registers clear: after that edge, `busy_o`, `done_o`, `illegal_o` and `result_o` are all 0 and the cycle count restarts.
- R2: A `start_i` high in a cycle where `busy_o` is low makes `busy_o` high from the next cycle on. It stays high until the operation completes or is aborted.
- R3: Call the start cycle cycle 0. If `cop_valid_i` is high in cycle k, with 1 <= k <= `TMO_LIMIT`, then in cycle k+1 `done_o` is high for exactly one cycle, `busy_o` is low and `illegal_o` stays low.
- R4: On an accepted completion, `result_o` takes the value that `cop_result_i` had in the valid cycle. It keeps that value until the next accepted completion.
- R5: If `cop_valid_i` stays low in cycles 1 to `TMO_LIMIT`, then in cycle `TMO_LIMIT`+1 `busy_o` is low and `illegal_o` is high for exactly one cycle, and `done_o` stays low.
- R6: A `start_i` while `busy_o` is high has no effect. The deadline is still measured from the original start.
- R7: A `cop_valid_i` while `busy_o` is low has no effect: no `done_o` pulse, and `result_o` is unchanged. This includes a valid that arrives after an abort.
- R8: A valid in cycle `TMO_LIMIT` exactly, the last allowed cycle, counts as a success and not as a timeout.
- R9: When `start_i` and `cop_valid_i` are high together in an idle cycle, the start is accepted and that valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle operation start strobe |
| cop_valid_i | input | 1 | One-cycle completion pulse from the coprocessor |
| cop_result_i | input | DATA_W (32) | Coprocessor result, meaningful only while `cop_valid_i` is high |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: the operation completed in time |
| illegal_o | output | 1 | One-cycle pulse: the operation timed out, raise an illegal-instruction exception |
| result_o | output | DATA_W (32) | Result latched from the last accepted completion |

## Verification
The bench puts a valid on the last allowed cycle and another on the first cycle past the deadline. An off-by-one counter would turn the first into a timeout or let the second through as a success. It also strobes start in the middle of an operation. A design that restarts its counter on that strobe would give done or illegal too late. Stray valids are sent while idle, after an abort and in the start cycle itself. A design that does not gate completion by the busy state would pulse done on these or overwrite the latched result. A reset is applied in the middle of an operation, and this must leave no pending busy state and no event behind.

// File: rtl/cop_tmo_pkg.sv
// Package: types shared by the timeout supervisor modules.
// Assumes: nothing beyond IEEE 1800-2017.
package cop_tmo_pkg;
    // Outcome of an operation, as decided in one cycle.
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_OK    = 2'd1,
        OUT_ABORT = 2'd2
    } cop_outcome_e;

    // Width of a counter that holds values 0 .. limit-1.
    function automatic int cnt_width(input int limit);
        return (limit > 2) ? $clog2(limit) : 1;
    endfunction
endpackage

// File: rtl/cop_tmo_counter.sv
// Module: counts the cycles elapsed since an accepted start.
// Assumes: clr has priority over inc; the owner clears it on every start and finish.
module cop_tmo_counter #(
    parameter int LIMIT = 512,
    localparam int CW   = cop_tmo_pkg::cnt_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Elapsed-cycle register: clear on request, otherwise step while running.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    // Flags the last cycle in which a completion is still accepted.
    always_comb last = (cnt_q == LAST_V);

    assign cnt = cnt_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_V); // R5
endmodule

// File: rtl/cop_tmo_ctrl.sv
// Module: handshake control of the supervisor: busy flag and outcome pulses.
// Assumes: start and valid are single-cycle strobes; last is high in the final
// allowed busy cycle.
module cop_tmo_ctrl
    import cop_tmo_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         valid,
    input  logic         last,
    output logic         busy,
    output logic         take_start,
    output logic         cnt_clr,
    output logic         cnt_inc,
    output logic         capture,
    output cop_outcome_e outcome
);
    logic busy_q;
    logic fin_ok;
    logic fin_to;
    cop_outcome_e outcome_q;

    // Decode the events of the current cycle from the busy state.
    always_comb begin
        take_start = start & ~busy_q;
        fin_ok     = busy_q & valid;
        fin_to     = busy_q & ~valid & last;
        cnt_clr    = take_start | fin_ok | fin_to;
        cnt_inc    = busy_q & ~cnt_clr;
        capture    = fin_ok;
    end

    // Busy flag: set by an accepted start, cleared by success or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_q <= 1'b0;
        else if (take_start)       busy_q <= 1'b1;
        else if (fin_ok || fin_to) busy_q <= 1'b0;
    end

    // One-cycle outcome register, cleared when nothing finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)      outcome_q <= OUT_NONE;
        else if (fin_ok) outcome_q <= OUT_OK;
        else if (fin_to) outcome_q <= OUT_ABORT;
        else             outcome_q <= OUT_NONE;
    end

    assign busy    = busy_q;
    assign outcome = outcome_q;

    AST_OK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && valid) |=> (outcome_q == OUT_OK && !busy_q)); // R3
    AST_IDLE_VALID_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && valid) |=> (outcome_q != OUT_OK)); // R7
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && start) |=> busy_q); // R2
    AST_OUTCOME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome_q != OUT_NONE) |=> (outcome_q == OUT_NONE)); // R3
endmodule

// File: rtl/cop_tmo_capture.sv
// Module: result holding register loaded on an accepted completion.
// Assumes: the data input is valid only in the cycle load is high.
module cop_tmo_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    // Hold the last accepted result.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_r <= '0;
        else if (load) q_r <= d;
    end

    assign q = q_r;

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q_r)); // R4
endmodule

// File: rtl/cop_timeout_mon.sv
// Module: top of the coprocessor timeout supervisor.
// Assumes: one operation in flight at most; operands stay stable until the
// operation ends; TMO_LIMIT >= 2.
module cop_timeout_mon
    import cop_tmo_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int TMO_LIMIT = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cop_valid_i,
    input  logic [DATA_W-1:0] cop_result_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int CW = cnt_width(TMO_LIMIT);

    logic          busy;
    logic          take_start;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          capture;
    logic          last;
    logic [CW-1:0] cnt;
    cop_outcome_e  outcome;

    cop_tmo_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .valid      (cop_valid_i),
        .last       (last),
        .busy       (busy),
        .take_start (take_start),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .capture    (capture),
        .outcome    (outcome)
    );

    cop_tmo_counter #(.LIMIT(TMO_LIMIT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt),
        .last  (last)
    );

    cop_tmo_capture #(.W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (capture),
        .d     (cop_result_i),
        .q     (result_o)
    );

    // Map the outcome code onto the output pulses.
    always_comb begin
        busy_o    = busy;
        done_o    = (outcome == OUT_OK);
        illegal_o = (outcome == OUT_ABORT);
    end

    AST_TIMEOUT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cop_valid_i && cnt == CW'(TMO_LIMIT - 1)) |=> (illegal_o && !busy_o)); // R5
    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && illegal_o)); // R3
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && !cop_valid_i && cnt != CW'(TMO_LIMIT - 1))
        |=> (busy && cnt == $past(cnt) + 1'b1)); // R6
    AST_RESULT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cop_valid_i) |=> (result_o == $past(cop_result_i))); // R4
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> !illegal_o); // R5
endmodule

// File: tb/cop_timeout_mon_tb_top.sv
module cop_timeout_mon_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIM        = 12;
    localparam int DW         = 32;

    typedef struct {
        bit          is_abort;
        int          at;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cop_valid_i = 1'b0;
    logic [DW-1:0] cop_result_i = '0;
    logic          busy_o, done_o, illegal_o;
    logic [DW-1:0] result_o;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    exp_t sb[$];
    logic [31:0] last_res = '0;

    cop_timeout_mon #(.DATA_W(DW), .TMO_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cop_valid_i(cop_valid_i),
        .cop_result_i(cop_result_i), .busy_o(busy_o), .done_o(done_o),
        .illegal_o(illegal_o), .result_o(result_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(input bit ok, input string tag, input logic [31:0] act,
                                input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endfunction

    // Monitor: pop the expected event whenever an outcome pulse shows up.
    always @(negedge clk) begin
        if (rst_n && (done_o || illegal_o)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected event", {30'd0, done_o, illegal_o}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(illegal_o == e.is_abort && done_o == !e.is_abort, e.tag,
                    {30'd0, done_o, illegal_o}, e.is_abort ? 32'd1 : 32'd2);
                chk(cyc == e.at, e.tag, cyc, e.at);
                if (!e.is_abort) chk(result_o == e.data, {e.tag, " R4 data"}, result_o, e.data);
            end
        end
    end

    // Driver: one operation; valid comes d cycles after the start cycle.
    task automatic op(input int d, input logic [31:0] data, input bit mid_start,
                      input bit same_valid, input string tag);
        int   s;
        exp_t e;
        @(negedge clk);
        s = cyc;
        start_i = 1'b1;
        if (same_valid) begin cop_valid_i = 1'b1; cop_result_i = 32'hBAD0_0000 | s; end
        e.is_abort = (d > LIM);
        e.at       = (d > LIM) ? s + LIM + 1 : s + d + 1;
        e.data     = data;
        e.tag      = tag;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        cop_valid_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        while (cyc != s + d) begin
            if (mid_start && cyc == s + 2) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        cop_valid_i  = 1'b1;
        cop_result_i = data;
        @(negedge clk);
        cop_valid_i  = 1'b0;
        cop_result_i = 32'h5A5A_5A5A;
        chk(busy_o == 1'b0, {tag, " busy cleared"}, busy_o, 0);
        if (d <= LIM) last_res = data;
        else chk(result_o == last_res, "R7 late valid kept result", result_o, last_res);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && illegal_o == 0, "R1 reset outputs",
            {29'd0, busy_o, done_o, illegal_o}, 0);
        chk(result_o == 0, "R1 reset result", result_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        op(1, 32'h1111_0001, 0, 0, "R3 k=1");
        op(5, 32'h2222_0005, 0, 0, "R3 k=5");
        op(LIM, 32'h3333_000C, 0, 0, "R8 last allowed cycle");
        op(LIM + 1, 32'h4444_000D, 0, 0, "R5 timeout, R7 late valid");
        op(20, 32'h5555_0014, 1, 0, "R5 R6 timeout with mid start");
        op(7, 32'h6666_0007, 1, 0, "R6 mid start success");
        op(3, 32'h7777_0003, 0, 1, "R9 start with valid");

        // R7: idle valid is dropped and the held result stays.
        @(negedge clk);
        cop_valid_i = 1'b1; cop_result_i = 32'hDEAD_BEEF;
        @(negedge clk);
        cop_valid_i = 1'b0;
        chk(done_o == 0 && busy_o == 0, "R7 idle valid no done", {30'd0, done_o, busy_o}, 0);
        chk(result_o == last_res, "R7 idle valid result kept", result_o, last_res);

        // R1: reset in the middle of an operation leaves nothing pending.
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 0 && result_o == 0, "R1 mid-op reset", {31'd0, busy_o}, 0);
        rst_n = 1'b1;
        repeat (LIM + 4) @(negedge clk);
        chk(illegal_o == 0 && busy_o == 0, "R1 no abort after reset", {31'd0, illegal_o}, 0);

        op(2, 32'h8888_0002, 0, 0, "R3 after reset");
        chk(sb.size() == 0, "R3 all expected events seen", sb.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule